// File: doc/BRIEF.md
# Packed Lane Arithmetic with Greater-Equal Flags and Byte Select

This block performs packed arithmetic on a 32-bit word. It splits the word into two 16-bit halves or four 8-bit bytes, and each lane adds or subtracts on its own, as signed or unsigned values. Two cross forms pair each half of A with the opposite half of B: one subtracts in the low half and adds in the high half, and the other does the reverse. Every arithmetic operation yields one greater-equal flag per byte. A 16-bit lane drives both of its byte flags with the same value. When the caller asks for it, those flags are stored in a 4-bit flag register.

A select operation reads the stored flags and builds its result byte by byte. Each byte comes from A or from B. Software can therefore compare with a packed operation and then merge with select, with no branch per lane.

Operations enter on a valid/ready port and results leave on a valid/ready port through one output register. The input is ready whenever the output register is empty, or when it is being drained in the same cycle. An accepted operation appears on `res_data` in the cycle after the accepting edge. A result that is not taken stays on the port, unchanged, until `res_ready` is high at a clock edge. The flag register is not part of the stream: it is a plain status output.

Top module: `simd_ge_unit`

## Requirements
- R1: After reset, `res_valid` is 0, `in_ready` is 1 and `ge_flags` is 0000.
- R2: Opcode `in_op`: 0 is lane add, 1 is lane subtract, 2 is the cross form (low half A.lo-B.hi, high half A.hi+B.lo), 3 is the other cross form (low half A.lo+B.hi, high half A.hi-B.lo), and any value with bit 2 set is select. With `in_byte`=0, add and subtract work on two 16-bit lanes. Each lane wraps modulo 2^16 and no carry crosses between lanes.
- R3: With `in_byte`=1, add and subtract work on four 8-bit lanes. Each lane wraps modulo 2^8 and no carry crosses between lanes. The cross forms ignore `in_byte` and always use 16-bit halves.
- R4: In a 16-bit lane of a signed add, a signed subtract or an unsigned subtract, both flags of the lane (bits 2h+1 and 2h for half h) are 1 when the exact result is at least 0, and 0 otherwise.
- R5: In a 16-bit lane of an unsigned add, both flags of the lane are 1 when the exact sum is at least 0x10000, and 0 otherwise.
- R6: In byte mode, flag i is 1 when the exact result of byte i is at least 0. For an unsigned add, flag i is instead 1 when the exact sum of byte i is at least 0x100.
- R7: Each half of a cross form sets its flags by the rule for its own operation. If unsigned, the adding half uses the 0x10000 threshold and the subtracting half uses the 0 threshold. If signed, both halves use the 0 threshold.
- R8: Select outputs byte i of A when stored flag i is 1, and byte i of B when it is 0.
- R9: The flag register loads only on an accepted arithmetic operation with `in_ge_wr`=1. A select, or an arithmetic operation with `in_ge_wr`=0, leaves it unchanged.
- R10: An input is accepted when `in_valid` and `in_ready` are both 1, and `in_ready` equals (!`res_valid` || `res_ready`). While `res_valid` is 1 and `res_ready` is 0, `res_data` and `res_valid` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation present |
| in_ready | output | 1 | Unit can take an operation |
| in_op | input | 3 | Operation code (see R2) |
| in_byte | input | 1 | 1 selects 8-bit lanes for add and subtract |
| in_sgn | input | 1 | 1 treats the lanes as signed |
| in_ge_wr | input | 1 | Store the new flags on this operation |
| in_a | input | 32 | Operand A |
| in_b | input | 32 | Operand B |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| res_data | output | 32 | Result word |
| ge_flags | output | 4 | Stored greater-equal flags |

## Verification
The directed operands are chosen to sit right at each threshold. An unsigned sum of 0xFFFF+0x0001 carries out of its lane, so it separates the carry rule from the sign rule and shows that no carry reaches the neighbouring lane. A byte sum of 0x80+0x80 is checked both signed and unsigned, which catches a swapped signed/unsigned choice. Subtracting 4-5 and 5-4 shows which way the borrow test points. Running the two cross forms with their halves deliberately unequal shows whether the B halves are swapped and which half subtracts. Random operands, with random operations, modes, write strobes and stall lengths, are then checked against a model computed with integers. A select that follows a flag-setting operation, and one that follows an operation with the write strobe off, shows whether select reads the stored flags or the flags of the previous operation.

// File: rtl/simd_ge_pkg.sv
package simd_ge_pkg;
  localparam int LANE8_W  = 8;
  localparam int LANE16_W = 16;

  typedef enum logic [1:0] {
    K_ADD = 2'd0,
    K_SUB = 2'd1,
    K_SXA = 2'd2,
    K_AXS = 2'd3
  } arith_kind_e;
endpackage

// File: rtl/simd_lane_alu.sv
module simd_lane_alu #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         sgn,
  output logic [W-1:0] sum,
  output logic         ge
);
  logic [W+1:0] ea, eb, full;

  always_comb begin
    ea   = sgn ? {{2{a[W-1]}}, a} : {2'b00, a};
    eb   = sgn ? {{2{b[W-1]}}, b} : {2'b00, b};
    full = sub ? (ea - eb) : (ea + eb);
    sum  = full[W-1:0];
    // unsigned add: carry out of the lane; every other form: exact result non-negative
    ge   = (sgn || sub) ? ~full[W+1] : full[W];
  end
endmodule

// File: rtl/simd_lane_array.sv
module simd_lane_array
  import simd_ge_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]   a,
  input  logic [DATA_W-1:0]   b,
  input  arith_kind_e         kind,
  input  logic                byte_mode,
  input  logic                sgn,
  output logic [DATA_W-1:0]   res,
  output logic [DATA_W/8-1:0] ge_new
);
  localparam int NB = DATA_W / LANE8_W;
  localparam int NH = DATA_W / LANE16_W;

  logic [DATA_W-1:0] res8, res16;
  logic [NB-1:0]     ge8, ge16;
  logic              sub_all;
  logic              use_bytes;

  assign sub_all   = (kind == K_SUB);
  assign use_bytes = byte_mode && (kind == K_ADD || kind == K_SUB);

  for (genvar i = 0; i < NB; i++) begin : g_byte
    simd_lane_alu #(.W(LANE8_W)) u_lane (
      .a   (a[LANE8_W*i +: LANE8_W]),
      .b   (b[LANE8_W*i +: LANE8_W]),
      .sub (sub_all),
      .sgn (sgn),
      .sum (res8[LANE8_W*i +: LANE8_W]),
      .ge  (ge8[i])
    );
  end

  for (genvar h = 0; h < NH; h++) begin : g_half
    localparam int PARTNER = h ^ 1;
    logic [LANE16_W-1:0] bsel;
    logic                lane_sub;
    logic                g;
    always_comb begin
      if (kind == K_SXA || kind == K_AXS) bsel = b[LANE16_W*PARTNER +: LANE16_W];
      else                                bsel = b[LANE16_W*h +: LANE16_W];
      unique case (kind)
        K_ADD:   lane_sub = 1'b0;
        K_SUB:   lane_sub = 1'b1;
        K_SXA:   lane_sub = ((h % 2) == 0);
        default: lane_sub = ((h % 2) == 1);
      endcase
    end
    simd_lane_alu #(.W(LANE16_W)) u_lane (
      .a   (a[LANE16_W*h +: LANE16_W]),
      .b   (bsel),
      .sub (lane_sub),
      .sgn (sgn),
      .sum (res16[LANE16_W*h +: LANE16_W]),
      .ge  (g)
    );
    assign ge16[2*h +: 2] = {2{g}};
  end

  assign res    = use_bytes ? res8 : res16;
  assign ge_new = use_bytes ? ge8  : ge16;
endmodule

// File: rtl/simd_byte_sel.sv
module simd_byte_sel #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]   a,
  input  logic [DATA_W-1:0]   b,
  input  logic [DATA_W/8-1:0] pick_a,
  output logic [DATA_W-1:0]   y
);
  localparam int NB = DATA_W / 8;
  for (genvar i = 0; i < NB; i++) begin : g_mux
    assign y[8*i +: 8] = pick_a[i] ? a[8*i +: 8] : b[8*i +: 8];
  end
endmodule

// File: rtl/simd_ge_unit.sv
module simd_ge_unit
  import simd_ge_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int NB    = DATA_W / 8,
  localparam int NH    = DATA_W / 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        in_op,
  input  logic              in_byte,
  input  logic              in_sgn,
  input  logic              in_ge_wr,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [DATA_W-1:0] res_data,
  output logic [NB-1:0]     ge_flags
);
  logic              accept, is_sel, ge_load;
  arith_kind_e       kind;
  logic [DATA_W-1:0] arith_res, sel_res;
  logic [NB-1:0]     ge_new;

  assign in_ready = !res_valid || res_ready;
  assign accept   = in_valid && in_ready;
  assign is_sel   = in_op[2];
  assign kind     = arith_kind_e'(in_op[1:0]);
  assign ge_load  = accept && !is_sel && in_ge_wr;

  simd_lane_array #(.DATA_W(DATA_W)) u_lanes (
    .a         (in_a),
    .b         (in_b),
    .kind      (kind),
    .byte_mode (in_byte),
    .sgn       (in_sgn),
    .res       (arith_res),
    .ge_new    (ge_new)
  );

  simd_byte_sel #(.DATA_W(DATA_W)) u_sel (
    .a      (in_a),
    .b      (in_b),
    .pick_a (ge_flags),
    .y      (sel_res)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ge_flags <= '0;
    else if (ge_load) ge_flags <= ge_new;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else if (accept) begin
      res_valid <= 1'b1;
      res_data  <= is_sel ? sel_res : arith_res;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  // R10: stalled result holds
  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_data));

  // R10: empty output always accepts
  p_empty_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> in_ready);

  // R9: flags move only on a flagged arithmetic acceptance
  p_ge_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready && !in_op[2] && in_ge_wr) |=> $stable(ge_flags));

  for (genvar h = 0; h < NH; h++) begin : g_pair_chk
    // R4: a 16-bit lane drives both of its byte flags alike
    p_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready && !in_op[2] && in_ge_wr && (!in_byte || in_op[1])
      |=> ge_flags[2*h] == ge_flags[2*h+1]);
  end

  for (genvar i = 0; i < NB; i++) begin : g_sel_chk
    // R8: select byte follows the stored flag
    p_sel_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready && in_op[2]
      |=> res_data[8*i +: 8] == ($past(ge_flags[i]) ? $past(in_a[8*i +: 8])
                                                    : $past(in_b[8*i +: 8])));
  end
endmodule

// File: tb/sim_simd_ge_unit.sv
module sim_simd_ge_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_op = '0;
  logic        in_byte = 1'b0;
  logic        in_sgn = 1'b0;
  logic        in_ge_wr = 1'b0;
  logic [31:0] in_a = '0;
  logic [31:0] in_b = '0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic [31:0] res_data;
  logic [3:0]  ge_flags;

  int total = 0;
  int bad = 0;
  logic [3:0] ge_m = 4'h0;

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_ge_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_byte(in_byte), .in_sgn(in_sgn), .in_ge_wr(in_ge_wr),
    .in_a(in_a), .in_b(in_b), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .ge_flags(ge_flags)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int lane_calc(input int x, input int y, input bit sub, input bit sgn,
                                   input int w, output bit g);
    int full;
    full = sub ? x - y : x + y;
    if (!sgn && !sub) g = (full >= (1 << w));
    else              g = (full >= 0);
    return full;
  endfunction

  function automatic void model(input logic [31:0] a, input logic [31:0] b, input logic [2:0] op,
                                input logic bm, input logic sg, input logic [3:0] gin,
                                output logic [31:0] r, output logic [3:0] g);
    int x, y, f;
    bit gg, sb;
    logic [15:0] bh;
    r = '0; g = gin;
    if (op[2]) begin
      for (int i = 0; i < 4; i++) r[8*i +: 8] = gin[i] ? a[8*i +: 8] : b[8*i +: 8];
    end else if (bm && !op[1]) begin
      for (int i = 0; i < 4; i++) begin
        x = sg ? int'($signed(a[8*i +: 8])) : int'(a[8*i +: 8]);
        y = sg ? int'($signed(b[8*i +: 8])) : int'(b[8*i +: 8]);
        f = lane_calc(x, y, op[0], sg, 8, gg);
        r[8*i +: 8] = f[7:0];
        g[i] = gg;
      end
    end else begin
      for (int h = 0; h < 2; h++) begin
        bh = op[1] ? b[16*(1-h) +: 16] : b[16*h +: 16];
        sb = (op[1:0] == 2'd1) || (op[1:0] == 2'd2 && h == 0) || (op[1:0] == 2'd3 && h == 1);
        x = sg ? int'($signed(a[16*h +: 16])) : int'(a[16*h +: 16]);
        y = sg ? int'($signed(bh)) : int'(bh);
        f = lane_calc(x, y, sb, sg, 16, gg);
        r[16*h +: 16] = f[15:0];
        g[2*h +: 2] = {gg, gg};
      end
    end
  endfunction

  task automatic run(input logic [31:0] a, input logic [31:0] b, input logic [2:0] op,
                     input logic bm, input logic sg, input logic wr, input int stall,
                     input string req);
    logic [31:0] er;
    logic [3:0]  gn, eg;
    model(a, b, op, bm, sg, ge_m, er, gn);
    eg = (!op[2] && wr) ? gn : ge_m;
    @(negedge clk);
    in_a = a; in_b = b; in_op = op; in_byte = bm; in_sgn = sg; in_ge_wr = wr;
    in_valid = 1'b1; res_ready = 1'b0;
    chk(in_ready == 1'b1, "R10 ready when empty", {31'd0, in_ready}, 32'd1);
    @(negedge clk);
    in_valid = 1'b0;
    chk(res_valid == 1'b1, "R10 valid after accept", {31'd0, res_valid}, 32'd1);
    chk(res_data == er, req, res_data, er);
    chk(ge_flags == eg, "R9 flag register", {28'd0, ge_flags}, {28'd0, eg});
    ge_m = eg;
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk(res_valid && res_data == er && !in_ready, "R10 stall hold", res_data, er);
    end
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    chk(res_valid == 1'b0, "R10 drained", {31'd0, res_valid}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired act=%h exp=%h", 32'd0, 32'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    chk(res_valid == 1'b0 && in_ready == 1'b1, "R1 reset stream", {30'd0, res_valid, in_ready}, 32'd1);
    chk(ge_flags == 4'h0, "R1 reset flags", {28'd0, ge_flags}, 32'd0);
    rst_n = 1'b1;

    // R2/R5: unsigned halves, low lane carries out but not into high lane
    run(32'h0001_FFFF, 32'h0001_0001, 3'd0, 1'b0, 1'b0, 1'b1, 1, "R2 R5 unsigned add16");
    // R8: select with flags 0011
    run(32'hAABB_CCDD, 32'h1122_3344, 3'd4, 1'b0, 1'b0, 1'b1, 0, "R8 select");
    // R4: signed halves, 0x7FFF+1 overflows to negative
    run(32'hFFFE_7FFF, 32'h0003_0001, 3'd0, 1'b0, 1'b1, 1'b1, 2, "R2 R4 signed add16");
    // R4: unsigned subtract borrow sense
    run(32'h0004_0005, 32'h0005_0004, 3'd1, 1'b0, 1'b0, 1'b1, 0, "R4 unsigned sub16");
    // R6/R3: byte unsigned add threshold 0x100
    run(32'h80FF_0180, 32'h8001_FF7F, 3'd0, 1'b1, 1'b0, 1'b1, 0, "R3 R6 unsigned add8");
    run(32'hDEAD_BEEF, 32'h0123_4567, 3'd5, 1'b0, 1'b0, 1'b0, 1, "R8 select byte flags");
    // R6: byte signed add
    run(32'h80FF_0180, 32'h8001_FF7F, 3'd0, 1'b1, 1'b1, 1'b1, 0, "R6 signed add8");
    run(32'h0405_0005, 32'h0504_0500, 3'd1, 1'b1, 1'b0, 1'b1, 0, "R6 unsigned sub8");
    // R7: cross forms
    run(32'hFFFF_0003, 32'h0001_0005, 3'd2, 1'b0, 1'b0, 1'b1, 0, "R7 cross sub-lo add-hi unsigned");
    run(32'h0003_FFFF, 32'h0005_0001, 3'd3, 1'b0, 1'b0, 1'b1, 0, "R7 cross add-lo sub-hi unsigned");
    run(32'h7FFF_8000, 32'h0001_0001, 3'd2, 1'b1, 1'b1, 1'b1, 0, "R7 R3 cross signed ignores byte");
    // R9: write strobe off leaves flags, select leaves flags
    run(32'h0000_0000, 32'h0001_0001, 3'd1, 1'b0, 1'b0, 1'b0, 0, "R9 no write");
    run(32'h1111_1111, 32'h2222_2222, 3'd6, 1'b0, 1'b0, 1'b1, 0, "R9 select keeps flags");

    for (int n = 0; n < 400; n++) begin
      logic [2:0] op;
      op = ($urandom % 6 == 0) ? 3'd4 : 3'($urandom % 4);
      run($urandom, $urandom, op, 1'($urandom), 1'($urandom), 1'($urandom % 4 != 0),
          int'($urandom % 3), "R2 R3 R4 R5 R6 R7 R8 random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule